// File: doc/BRIEF.md
# Real-time clock with minute-rounding adjust

This block keeps time of day as six BCD digits (seconds, minutes and hours, 24-hour range). A single-cycle enable at 32.768 kHz drives a two-stage sub-second divider. The first stage divides down to 1/256 s and the second stage divides down to one second. A host reaches the digits and a control register over a simple register bus that has a write strobe, a read strobe, a 4-bit address and 4-bit data.

Setting the adjust bit in the control register starts a correction that snaps the time to the nearest whole minute. In the first tick of the correction the seconds go to 00. If the seconds were 30 or above, the minutes also step up by one, and that carry can reach the hours. The same tick clears both divider stages. The correction then holds a busy window for a fixed number of ticks. During that window the adjust bit reads 1, the counter address range 0x0 to 0xC is locked, and software polls the adjust bit until it reads 0.

Top module: `rtc_round_adjust`

## Requirements
- R1: After reset the time reads 00:00:00 on every digit, the control register at 0xD reads 0, and `adj_active` is 0.
- R2: The seconds advance once every PRE_DIV*SUB_DIV ticks. The seconds and minutes wrap from 59 to 00 and the hours wrap from 23 to 00, all in BCD, and each wrap carries into the next digit pair.
- R3: A correction whose first tick sees seconds 00 to 29 sets the seconds to 00 and leaves the minutes and hours unchanged.
- R4: A correction whose first tick sees seconds 30 to 59 sets the seconds to 00 and adds one minute, carrying into the hours and wrapping 23:59 to 00:00.
- R5: The first tick of a correction clears both divider stages, so the next second begins exactly PRE_DIV*SUB_DIV ticks after that tick.
- R6: The busy window lasts exactly BUSY_TICKS ticks, counting the rounding tick. After the last of those ticks the adjust bit (bit 0 of 0xD) and `adj_active` return to 0 without any host action.
- R7: While busy, writes to addresses 0x0 to 0xC are ignored.
- R8: While busy, a read of 0x0 to 0xC returns 0 and sets the sticky error flag (bit 1 of 0xD). Writing 0xD with bit 1 = 0 clears the flag, and writing bit 1 = 1 leaves it unchanged.
- R9: Address 0xD stays readable during the busy window, and bit 0 reads 1 there.
- R10: Writing 1 to the adjust bit while busy neither restarts nor lengthens the window.
- R11: The digit map is 0x0 seconds units, 0x1 seconds tens, 0x2 minutes units, 0x3 minutes tens, 0x4 hours units, 0x5 hours tens. When not busy these are writable and read back. Addresses 0x6 to 0xC, 0xE and 0xF read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | One-cycle enable at the 32.768 kHz rate |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Registered read data, valid the cycle after `bus_re` |
| adj_active | output | 1 | High during the correction busy window |

## Verification
Read data is registered, so each read is sampled on the falling edge one cycle after the read strobe. The bench works out the expected value just before it issues the strobe, which means the error flag seen is the flag from before that read. A write that starts a correction sets `adj_active` on the next rising edge. The rounding, the divider clear and each busy-count step happen on the rising edge of a tick cycle, and the bench samples all of them on the falling edge that follows. The bench drives ticks and bus strobes in separate cycles, so its reference model steps exactly once per tick and once per bus access.

// File: rtl/rtc_adj_pkg.sv
package rtc_adj_pkg;
  localparam int DIGIT_W = 4;
  localparam int ADDR_W  = 4;

  typedef struct packed {
    logic [DIGIT_W-1:0] ht;
    logic [DIGIT_W-1:0] hu;
    logic [DIGIT_W-1:0] mt;
    logic [DIGIT_W-1:0] mu;
    logic [DIGIT_W-1:0] st;
    logic [DIGIT_W-1:0] su;
  } rtc_time_t;

  localparam logic [ADDR_W-1:0] A_SU       = 4'h0;
  localparam logic [ADDR_W-1:0] A_ST       = 4'h1;
  localparam logic [ADDR_W-1:0] A_MU       = 4'h2;
  localparam logic [ADDR_W-1:0] A_MT       = 4'h3;
  localparam logic [ADDR_W-1:0] A_HU       = 4'h4;
  localparam logic [ADDR_W-1:0] A_HT       = 4'h5;
  localparam logic [ADDR_W-1:0] A_LOCK_TOP = 4'hC;
  localparam logic [ADDR_W-1:0] A_CTRL     = 4'hD;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRE_DIV = 128,
  parameter int SUB_DIV = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clr,
  output logic sec_pulse
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam int SUB_W = (SUB_DIV > 1) ? $clog2(SUB_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_DIV - 1);

  logic [PRE_W-1:0] pre_q;
  logic [SUB_W-1:0] sub_q;
  logic pre_wrap, sub_wrap;

  assign pre_wrap  = (pre_q == PRE_LAST);
  assign sub_wrap  = (sub_q == SUB_LAST);
  assign sec_pulse = tick && !clr && pre_wrap && sub_wrap;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre_q <= '0;
      sub_q <= '0;
    end else if (tick) begin
      if (pre_wrap) begin
        pre_q <= '0;
        sub_q <= sub_wrap ? '0 : sub_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  // R5
  clr_empties_chain_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pre_q == '0 && sub_q == '0));

  // R2
  pre_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pre_q <= PRE_LAST && sub_q <= SUB_LAST);
endmodule

// File: rtl/rtc_adjust_ctrl.sv
module rtc_adjust_ctrl #(
  parameter int BUSY_TICKS = 2500
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic start_req,
  output logic busy,
  output logic round_now
);
  localparam int CW = (BUSY_TICKS > 1) ? $clog2(BUSY_TICKS) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(BUSY_TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign round_now = busy && tick && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (!busy) begin
      cnt_q <= '0;
      if (start_req) busy <= 1'b1;
    end else if (tick) begin
      if (cnt_q == CNT_LAST) begin
        busy  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R6
  busy_ends_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(tick));

  // R6
  busy_count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_LAST);

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start_req && !tick) |=> (busy && cnt_q == $past(cnt_q)));
endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_adj_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sec_pulse,
  input  logic       round_now,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [3:0] wr_data,
  output rtc_time_t  time_q
);
  rtc_time_t nxt;

  function automatic rtc_time_t bump_hour(input rtc_time_t t);
    rtc_time_t r = t;
    if (t.ht == 4'd2 && t.hu == 4'd3) begin
      r.ht = 4'd0;
      r.hu = 4'd0;
    end else if (t.hu == 4'd9) begin
      r.hu = 4'd0;
      r.ht = t.ht + 4'd1;
    end else begin
      r.hu = t.hu + 4'd1;
    end
    return r;
  endfunction

  function automatic rtc_time_t bump_minute(input rtc_time_t t);
    rtc_time_t r = t;
    if (t.mu != 4'd9) begin
      r.mu = t.mu + 4'd1;
    end else begin
      r.mu = 4'd0;
      if (t.mt != 4'd5) r.mt = t.mt + 4'd1;
      else begin
        r.mt = 4'd0;
        r = bump_hour(r);
      end
    end
    return r;
  endfunction

  function automatic rtc_time_t bump_second(input rtc_time_t t);
    rtc_time_t r = t;
    if (t.su != 4'd9) begin
      r.su = t.su + 4'd1;
    end else begin
      r.su = 4'd0;
      if (t.st != 4'd5) r.st = t.st + 4'd1;
      else begin
        r.st = 4'd0;
        r = bump_minute(r);
      end
    end
    return r;
  endfunction

  always_comb begin
    nxt = time_q;
    if (round_now) begin
      nxt.su = 4'd0;
      nxt.st = 4'd0;
      if (time_q.st >= 4'd3) nxt = bump_minute(nxt);
    end else if (sec_pulse) begin
      nxt = bump_second(time_q);
    end
    if (wr_en) begin
      case (wr_sel)
        3'd0:    nxt.su = wr_data;
        3'd1:    nxt.st = wr_data;
        3'd2:    nxt.mu = wr_data;
        3'd3:    nxt.mt = wr_data;
        3'd4:    nxt.hu = wr_data;
        3'd5:    nxt.ht = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) time_q <= '0;
    else     time_q <= nxt;
  end

  // R3
  round_zero_sec_chk: assert property (@(posedge clk) disable iff (rst)
    (round_now && !wr_en) |=> (time_q.su == 4'd0 && time_q.st == 4'd0));

  // R3
  round_down_keeps_min_chk: assert property (@(posedge clk) disable iff (rst)
    (round_now && !wr_en && time_q.st < 4'd3) |=>
      (time_q.mu == $past(time_q.mu) && time_q.mt == $past(time_q.mt)));
endmodule

// File: rtl/rtc_bus_if.sv
module rtc_bus_if
  import rtc_adj_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        busy,
  input  rtc_time_t   time_q,
  input  logic [3:0]  addr,
  input  logic        we,
  input  logic        re,
  input  logic [3:0]  wdata,
  output logic [3:0]  rdata,
  output logic        start_req,
  output logic        time_wr_en,
  output logic [2:0]  time_wr_sel
);
  logic locked_addr, blocked, err_q;

  assign locked_addr = (addr <= A_LOCK_TOP);
  assign blocked     = busy && locked_addr;
  assign time_wr_en  = we && !blocked && (addr <= A_HT);
  assign time_wr_sel = addr[2:0];
  assign start_req   = we && (addr == A_CTRL) && wdata[0];

  always_ff @(posedge clk) begin
    if (rst)                                         err_q <= 1'b0;
    else if (re && blocked)                          err_q <= 1'b1;
    else if (we && addr == A_CTRL && !wdata[1])      err_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      if (blocked) rdata <= '0;
      else begin
        case (addr)
          A_SU:    rdata <= time_q.su;
          A_ST:    rdata <= time_q.st;
          A_MU:    rdata <= time_q.mu;
          A_MT:    rdata <= time_q.mt;
          A_HU:    rdata <= time_q.hu;
          A_HT:    rdata <= time_q.ht;
          A_CTRL:  rdata <= {2'b00, err_q, busy};
          default: rdata <= '0;
        endcase
      end
    end
  end

  // R8
  blocked_read_chk: assert property (@(posedge clk) disable iff (rst)
    (re && blocked) |=> (rdata == 4'd0 && err_q));

  // R9
  ctrl_visible_chk: assert property (@(posedge clk) disable iff (rst)
    (re && busy && addr == A_CTRL) |=> rdata[0]);
endmodule

// File: rtl/rtc_round_adjust.sv
module rtc_round_adjust
  import rtc_adj_pkg::*;
#(
  parameter int PRE_DIV    = 128,
  parameter int SUB_DIV    = 256,
  parameter int BUSY_TICKS = 2500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_32k,
  input  logic [3:0] bus_addr,
  input  logic       bus_we,
  input  logic       bus_re,
  input  logic [3:0] bus_wdata,
  output logic [3:0] bus_rdata,
  output logic       adj_active
);
  rtc_time_t  time_q;
  logic       sec_pulse, round_now, busy, start_req, time_wr_en;
  logic [2:0] time_wr_sel;

  rtc_prescaler #(.PRE_DIV(PRE_DIV), .SUB_DIV(SUB_DIV)) u_pre (
    .clk(clk), .rst(rst), .tick(tick_32k), .clr(round_now), .sec_pulse(sec_pulse)
  );

  rtc_adjust_ctrl #(.BUSY_TICKS(BUSY_TICKS)) u_adj (
    .clk(clk), .rst(rst), .tick(tick_32k), .start_req(start_req),
    .busy(busy), .round_now(round_now)
  );

  rtc_time_counter u_time (
    .clk(clk), .rst(rst), .sec_pulse(sec_pulse), .round_now(round_now),
    .wr_en(time_wr_en), .wr_sel(time_wr_sel), .wr_data(bus_wdata), .time_q(time_q)
  );

  rtc_bus_if u_bus (
    .clk(clk), .rst(rst), .busy(busy), .time_q(time_q), .addr(bus_addr),
    .we(bus_we), .re(bus_re), .wdata(bus_wdata), .rdata(bus_rdata),
    .start_req(start_req), .time_wr_en(time_wr_en), .time_wr_sel(time_wr_sel)
  );

  assign adj_active = busy;

  // R7
  locked_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_we && bus_addr <= A_HT && !round_now && !sec_pulse) |=>
      (time_q == $past(time_q)));

  // R4
  round_up_chk: assert property (@(posedge clk) disable iff (rst)
    (round_now && time_q.st >= 4'd3 && time_q.mu != 4'd9) |=>
      (time_q.mu == $past(time_q.mu) + 4'd1));
endmodule

// File: tb/rtc_round_adjust_test.sv
module rtc_round_adjust_test;
  localparam int PRE   = 2;
  localparam int SUB   = 4;
  localparam int BUSY  = 12;
  localparam int TPS   = PRE * SUB;
  localparam int DAY   = 86400;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_32k = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [3:0] bus_wdata = '0;
  logic [3:0] bus_rdata;
  logic       adj_active;

  int n_chk = 0, n_bad = 0;
  int m_sec = 0, m_phase = 0, m_bcnt = 0;
  bit m_busy = 0, m_err = 0;
  bit done = 0;

  rtc_round_adjust #(.PRE_DIV(PRE), .SUB_DIV(SUB), .BUSY_TICKS(BUSY)) uut (
    .clk(clk), .rst(rst), .tick_32k(tick_32k), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .adj_active(adj_active)
  );

  always #10 clk = ~clk;

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      finish_run();
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int digit_of(input int s, input int a);
    int ss = s % 60, mm = (s / 60) % 60, hh = s / 3600;
    case (a)
      0: return ss % 10;
      1: return ss / 10;
      2: return mm % 10;
      3: return mm / 10;
      4: return hh % 10;
      5: return hh / 10;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_read(input int a);
    if (a == 13) return (m_err ? 2 : 0) + (m_busy ? 1 : 0);
    if (m_busy && a <= 12) return 0;
    return digit_of(m_sec, a);
  endfunction

  function automatic int set_digit(input int s, input int a, input int v);
    int d[6];
    for (int i = 0; i < 6; i++) d[i] = digit_of(s, i);
    d[a] = v;
    return (d[5] * 10 + d[4]) * 3600 + (d[3] * 10 + d[2]) * 60 + d[1] * 10 + d[0];
  endfunction

  task automatic model_tick();
    if (m_busy && m_bcnt == 0) begin
      int s = m_sec % 60;
      m_sec = (m_sec - s + (s >= 30 ? 60 : 0)) % DAY;
      m_phase = 0;
    end else begin
      m_phase++;
      if (m_phase == TPS) begin
        m_phase = 0;
        m_sec = (m_sec + 1) % DAY;
      end
    end
    if (m_busy) begin
      m_bcnt++;
      if (m_bcnt == BUSY) begin
        m_busy = 0;
        m_bcnt = 0;
      end
    end
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_32k = 1'b1;
      @(negedge clk);
      tick_32k = 1'b0;
      model_tick();
      if ((i % 3) == 2) @(negedge clk);
    end
  endtask

  task automatic wr(input int a, input int v);
    bus_addr = 4'(a); bus_wdata = 4'(v); bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    if (a <= 5 && !m_busy) m_sec = set_digit(m_sec, a, v);
    if (a == 13) begin
      if (v[1] == 1'b0) m_err = 0;
      if (v[0] == 1'b1 && !m_busy) begin
        m_busy = 1;
        m_bcnt = 0;
      end
    end
  endtask

  task automatic rd_check(input int a, input string tag);
    int e = exp_read(a);
    bus_addr = 4'(a); bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    if (m_busy && a <= 12) m_err = 1;
    check(bus_rdata == 4'(e), tag, int'(bus_rdata), e);
  endtask

  task automatic set_time(input int h, input int m, input int s);
    wr(4, h % 10); wr(5, h / 10);
    wr(2, m % 10); wr(3, m / 10);
    wr(0, s % 10); wr(1, s / 10);
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < 6; a++) rd_check(a, tag);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    read_all("R1 time after reset");
    rd_check(13, "R1 control after reset");
    check(adj_active == 1'b0, "R1 adj_active after reset", int'(adj_active), 0);

    // R11 write and read back, unused addresses
    set_time(12, 34, 56);
    read_all("R11 digit readback");
    rd_check(7, "R11 unused address");
    rd_check(14, "R11 unused address");

    // R2 counting and full rollover
    do_ticks(TPS);
    read_all("R2 one second");
    set_time(23, 59, 58);
    do_ticks(2 * TPS + 3);
    read_all("R2 day rollover");

    // R3 round down
    set_time(10, 20, 15);
    wr(13, 1);
    check(adj_active == 1'b1, "R6 busy after start", int'(adj_active), 1);
    rd_check(13, "R9 adjust bit visible");
    do_ticks(BUSY - 1);
    check(adj_active == 1'b1, "R6 still busy before last tick", int'(adj_active), 1);
    do_ticks(1);
    check(adj_active == 1'b0, "R6 self clear", int'(adj_active), 0);
    rd_check(13, "R6 control after window");
    read_all("R3 round down");

    // R4 round up with carry through hours
    set_time(23, 59, 45);
    wr(13, 1);
    do_ticks(BUSY);
    read_all("R4 round up day wrap");
    set_time(8, 9, 30);
    wr(13, 1);
    do_ticks(BUSY);
    read_all("R4 round up minute carry");

    // R5 divider clear: start mid-second
    set_time(5, 0, 0);
    do_ticks(TPS - 1);
    wr(13, 1);
    do_ticks(BUSY);
    read_all("R5 divider cleared");
    do_ticks(TPS - (BUSY - 1) % TPS - 1);
    rd_check(0, "R5 just before next second");
    do_ticks(1);
    rd_check(0, "R5 at next second");

    // R7 and R8 during busy
    set_time(1, 2, 3);
    wr(13, 1);
    do_ticks(2);
    wr(0, 7);
    wr(3, 4);
    rd_check(2, "R8 blocked read returns zero");
    rd_check(13, "R8 error flag set");
    wr(13, 2);
    rd_check(13, "R8 error kept on bit1=1");
    do_ticks(BUSY - 2);
    read_all("R7 blocked write ignored");
    wr(13, 0);
    rd_check(13, "R8 error cleared");

    // R10 retrigger does not extend
    wr(13, 1);
    do_ticks(5);
    wr(13, 1);
    do_ticks(BUSY - 6);
    check(adj_active == 1'b1, "R10 busy before original end", int'(adj_active), 1);
    do_ticks(1);
    check(adj_active == 1'b0, "R10 ends on original schedule", int'(adj_active), 0);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 9);
      if (op < 4) do_ticks($urandom_range(1, 20));
      else if (op < 6) rd_check($urandom_range(0, 15), "R2 random read");
      else if (op == 6) begin
        if (!m_busy) set_time($urandom_range(0, 23), $urandom_range(0, 59), $urandom_range(0, 59));
        else wr($urandom_range(0, 5), $urandom_range(0, 9));
      end
      else if (op == 7) wr(13, 1 + 2 * $urandom_range(0, 1));
      else if (op == 8) wr(13, 0);
      else check(adj_active == m_busy, "R6 random adj_active", int'(adj_active), int'(m_busy));
    end
    do_ticks(BUSY);
    read_all("R4 final time");

    done = 1;
    finish_run();
  end
endmodule